// File: doc/BRIEF.md
# Serial Packet Memory Access Port

This block is a serial-peripheral slave that gives an external host byte-wide access to an internal packet and configuration store with an 11-bit address. It also hands back a status byte. Each transaction is framed by an active-low chip select. The first byte of every transaction is a command. Two commands stream data: a sequential write and a sequential read. Each of them carries the upper address bits inside the command byte itself and takes the lower eight address bits from the next byte. After that, data moves one byte at a time, and the address steps up by one after each byte until chip select is released.

The no-operation byte asks for status. Any other command byte is not executed here. It is passed to a neighbouring controller as a single-cycle strobe that carries the byte value. The serial pins are sampled on the system clock through synchronizers, so every protocol action happens in the system clock domain. The serial clock must therefore be several times slower than the system clock. The status byte is built from the controller's interrupt, command-ready and state-code inputs. A flag inside the port reports whether the port is ready.

Top module: `spi_pktmem_port`

## Requirements
- R1: The serial clock idles high. MOSI is sampled on the rising edge of SCLK, MSB first. MISO changes only after a falling edge of SCLK, also MSB first.
- R2: After chip select goes low, `miso_oe` is asserted and `miso` reads high once the port is ready. This holds until the first falling edge of SCLK.
- R3: A command byte with bits [7:3] = 5'b00011 (0x18 OR address[10:8]) starts a sequential write. The next byte gives address[7:0]. Every further complete byte is stored at the current address, and the address then increments.
- R4: A command byte with bits [7:3] = 5'b00111 (0x38 OR address[10:8]) starts a sequential read. The next byte gives address[7:0], and the byte after that is a dummy. Each byte clocked after the dummy returns the stored data from consecutive addresses, starting at the given address.
- R5: Byte 0xFF is a no-operation. In a transaction that begins with 0xFF, the second byte returns the status byte on MISO. Status bit 7 is port ready, bit 6 is `irq_pend`, bit 5 is `ctrl_ready`, and bits [4:0] are `ctrl_state`.
- R6: Any other first byte pulses `cmd_strobe` for exactly one clock, with `cmd_code` equal to that byte. Later bytes in the same transaction are ignored and write nothing.
- R7: When chip select rises in the middle of a byte, that partial byte is discarded. No memory write results from it.
- R8: The address counter wraps from 0x7FF to 0x000 during a sequential write or read.
- R9: After reset, `miso_oe` is low, `miso` is high and `cmd_strobe` is low.
- R10: `miso_oe` is low whenever chip select is high, apart from the synchronizer delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sclk | input | 1 | Serial clock from the host, idle high |
| csn | input | 1 | Active-low chip select |
| mosi | input | 1 | Serial data from the host |
| miso | output | 1 | Serial data to the host |
| miso_oe | output | 1 | Output enable for miso while selected |
| irq_pend | input | 1 | Interrupt-pending flag shown in status bit 6 |
| ctrl_ready | input | 1 | Controller command-ready flag shown in status bit 5 |
| ctrl_state | input | 5 | Controller state code shown in status bits [4:0] |
| cmd_strobe | output | 1 | One-cycle pulse for a forwarded command |
| cmd_code | output | 8 | Forwarded command byte, valid with cmd_strobe |

## Verification
Directed sequences cover the following cases:
- A write followed by a read at a mid-range address, which separates the address-high field in the command byte from the low-address byte and shows the dummy byte is skipped.
- A burst that crosses the top of the address space, which shows the counter wraps.
- A transaction cut off after four bits, which shows a partial byte is never stored.
- A forwarded command followed by bytes that would otherwise form a write, which shows that no data phase follows a forwarded command.

Random transactions mix writes of random length at random addresses, read-backs checked against a byte-level model, status requests under random controller inputs, and random forwarded codes. Together they show that the command kinds never leak into one another.

// File: rtl/spm_pkg.sv
package spm_pkg;

    localparam int BYTE_W = 8;

    localparam logic [4:0] OPC_WR_SEQ = 5'b00011;
    localparam logic [4:0] OPC_RD_SEQ = 5'b00111;
    localparam logic [7:0] OPC_NOP    = 8'hFF;

    typedef enum logic [2:0] {
        PH_CMD,
        PH_ADDR,
        PH_DUMMY,
        PH_WDATA,
        PH_RDATA,
        PH_STAT,
        PH_SKIP
    } phase_e;

    typedef enum logic [1:0] {
        CK_WRITE,
        CK_READ,
        CK_NOP,
        CK_OTHER
    } cmd_kind_e;

    typedef struct packed {
        logic       port_ready;
        logic       irq;
        logic       ctrl_rdy;
        logic [4:0] state;
    } status_t;

    function automatic cmd_kind_e classify(input logic [7:0] b);
        if (b == OPC_NOP)
            return CK_NOP;
        else if (b[7:3] == OPC_WR_SEQ)
            return CK_WRITE;
        else if (b[7:3] == OPC_RD_SEQ)
            return CK_READ;
        else
            return CK_OTHER;
    endfunction

endpackage

// File: rtl/spm_sync.sv
module spm_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic sclk_i,
    input  logic csn_i,
    input  logic mosi_i,
    output logic sclk_rise,
    output logic sclk_fall,
    output logic cs_start,
    output logic cs_act,
    output logic mosi_s
);
    logic [STAGES-1:0] sclk_sr, csn_sr, mosi_sr;
    logic sclk_d, csn_d;

    always_ff @(posedge clk) begin
        if (rst) begin
            sclk_sr <= '1;
            csn_sr  <= '1;
            mosi_sr <= '0;
            sclk_d  <= 1'b1;
            csn_d   <= 1'b1;
        end else begin
            sclk_sr <= {sclk_sr[STAGES-2:0], sclk_i};
            csn_sr  <= {csn_sr[STAGES-2:0], csn_i};
            mosi_sr <= {mosi_sr[STAGES-2:0], mosi_i};
            sclk_d  <= sclk_sr[STAGES-1];
            csn_d   <= csn_sr[STAGES-1];
        end
    end

    assign sclk_rise = sclk_sr[STAGES-1] & ~sclk_d;
    assign sclk_fall = ~sclk_sr[STAGES-1] & sclk_d;
    assign cs_act    = ~csn_sr[STAGES-1];
    assign cs_start  = ~csn_sr[STAGES-1] & csn_d;
    assign mosi_s    = mosi_sr[STAGES-1];
endmodule

// File: rtl/spm_shifter.sv
module spm_shifter
    import spm_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cs_act,
    input  logic              cs_start,
    input  logic              sclk_rise,
    input  logic              sclk_fall,
    input  logic              mosi_s,
    input  logic              tx_load,
    input  logic [BYTE_W-1:0] tx_byte,
    output logic              rx_valid,
    output logic [BYTE_W-1:0] rx_byte,
    output logic              miso,
    output logic              miso_oe
);
    localparam int CNT_W = $clog2(BYTE_W);

    logic [CNT_W-1:0]  bit_cnt;
    logic [BYTE_W-2:0] rx_sr;
    logic [BYTE_W-1:0] tx_sr;

    always_ff @(posedge clk) begin
        if (rst) begin
            bit_cnt  <= '0;
            rx_sr    <= '0;
            rx_byte  <= '0;
            rx_valid <= 1'b0;
            tx_sr    <= '0;
            miso     <= 1'b1;
            miso_oe  <= 1'b0;
        end else begin
            rx_valid <= 1'b0;
            if (!cs_act) begin
                bit_cnt <= '0;
                miso    <= 1'b1;
                miso_oe <= 1'b0;
            end else begin
                miso_oe <= 1'b1;
                if (cs_start)
                    bit_cnt <= '0;
                if (sclk_fall) begin
                    miso  <= tx_sr[BYTE_W-1];
                    tx_sr <= {tx_sr[BYTE_W-2:0], 1'b0};
                end
                if (sclk_rise) begin
                    rx_sr   <= {rx_sr[BYTE_W-3:0], mosi_s};
                    bit_cnt <= bit_cnt + 1'b1;
                    if (bit_cnt == CNT_W'(BYTE_W - 1)) begin
                        rx_valid <= 1'b1;
                        rx_byte  <= {rx_sr, mosi_s};
                    end
                end
                if (tx_load)
                    tx_sr <= tx_byte;
            end
        end
    end
endmodule

// File: rtl/spm_seq.sv
module spm_seq
    import spm_pkg::*;
#(
    parameter int ADDR_W = 11
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cs_act,
    input  logic              cs_start,
    input  logic              rx_valid,
    input  logic [BYTE_W-1:0] rx_byte,
    input  logic [BYTE_W-1:0] rd_data,
    input  status_t           status,
    output logic              tx_load,
    output logic [BYTE_W-1:0] tx_byte,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [BYTE_W-1:0] mem_wdata,
    output logic              cmd_strobe,
    output logic [BYTE_W-1:0] cmd_code
);
    localparam int HI_W = ADDR_W - BYTE_W;

    phase_e            phase_q, phase_d;
    logic [ADDR_W-1:0] addr_q, addr_d;
    logic              rd_q, rd_d;
    logic              strobe_d;

    always_comb begin
        phase_d  = phase_q;
        addr_d   = addr_q;
        rd_d     = rd_q;
        strobe_d = 1'b0;
        tx_load  = 1'b0;
        tx_byte  = '0;
        mem_we   = 1'b0;
        if (cs_start) begin
            phase_d = PH_CMD;
            tx_load = 1'b1;
            tx_byte = status;
        end else if (rx_valid && cs_act) begin
            tx_load = 1'b1;
            unique case (phase_q)
                PH_CMD: begin
                    unique case (classify(rx_byte))
                        CK_WRITE: begin
                            addr_d[ADDR_W-1:BYTE_W] = rx_byte[HI_W-1:0];
                            rd_d    = 1'b0;
                            phase_d = PH_ADDR;
                        end
                        CK_READ: begin
                            addr_d[ADDR_W-1:BYTE_W] = rx_byte[HI_W-1:0];
                            rd_d    = 1'b1;
                            phase_d = PH_ADDR;
                        end
                        CK_NOP: begin
                            tx_byte = status;
                            phase_d = PH_STAT;
                        end
                        default: begin
                            strobe_d = 1'b1;
                            phase_d  = PH_SKIP;
                        end
                    endcase
                end
                PH_ADDR: begin
                    addr_d[BYTE_W-1:0] = rx_byte;
                    phase_d = rd_q ? PH_DUMMY : PH_WDATA;
                end
                PH_DUMMY, PH_RDATA: begin
                    tx_byte = rd_data;
                    addr_d  = addr_q + 1'b1;
                    phase_d = PH_RDATA;
                end
                PH_WDATA: begin
                    mem_we = 1'b1;
                    addr_d = addr_q + 1'b1;
                end
                PH_STAT: tx_byte = status;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q    <= PH_SKIP;
            addr_q     <= '0;
            rd_q       <= 1'b0;
            cmd_strobe <= 1'b0;
            cmd_code   <= '0;
        end else begin
            phase_q    <= phase_d;
            addr_q     <= addr_d;
            rd_q       <= rd_d;
            cmd_strobe <= strobe_d;
            if (strobe_d)
                cmd_code <= rx_byte;
        end
    end

    assign mem_addr  = addr_q;
    assign mem_wdata = rx_byte;
endmodule

// File: rtl/spm_mem.sv
module spm_mem
    import spm_pkg::*;
#(
    parameter int ADDR_W = 11
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [BYTE_W-1:0] wdata,
    output logic [BYTE_W-1:0] rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [BYTE_W-1:0] store [DEPTH];

    always_ff @(posedge clk) begin
        if (we)
            store[addr] <= wdata;
    end

    assign rdata = store[addr];
endmodule

// File: rtl/spi_pktmem_port.sv
module spi_pktmem_port
    import spm_pkg::*;
#(
    parameter int ADDR_W      = 11,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       sclk,
    input  logic       csn,
    input  logic       mosi,
    output logic       miso,
    output logic       miso_oe,
    input  logic       irq_pend,
    input  logic       ctrl_ready,
    input  logic [4:0] ctrl_state,
    output logic       cmd_strobe,
    output logic [7:0] cmd_code
);
    logic sclk_rise, sclk_fall, cs_start, cs_act, mosi_s;
    logic rx_valid, tx_load, mem_we, ready_q;
    logic [BYTE_W-1:0] rx_byte, tx_byte, mem_wdata, rd_data;
    logic [ADDR_W-1:0] mem_addr;
    status_t status;

    always_ff @(posedge clk) begin
        if (rst) ready_q <= 1'b0;
        else     ready_q <= 1'b1;
    end

    assign status = '{port_ready: ready_q, irq: irq_pend,
                      ctrl_rdy: ctrl_ready, state: ctrl_state};

    spm_sync #(.STAGES(SYNC_STAGES)) sync_i (
        .clk(clk), .rst(rst), .sclk_i(sclk), .csn_i(csn), .mosi_i(mosi),
        .sclk_rise(sclk_rise), .sclk_fall(sclk_fall),
        .cs_start(cs_start), .cs_act(cs_act), .mosi_s(mosi_s)
    );

    spm_shifter shift_i (
        .clk(clk), .rst(rst), .cs_act(cs_act), .cs_start(cs_start),
        .sclk_rise(sclk_rise), .sclk_fall(sclk_fall), .mosi_s(mosi_s),
        .tx_load(tx_load), .tx_byte(tx_byte),
        .rx_valid(rx_valid), .rx_byte(rx_byte),
        .miso(miso), .miso_oe(miso_oe)
    );

    spm_seq #(.ADDR_W(ADDR_W)) seq_i (
        .clk(clk), .rst(rst), .cs_act(cs_act), .cs_start(cs_start),
        .rx_valid(rx_valid), .rx_byte(rx_byte), .rd_data(rd_data),
        .status(status), .tx_load(tx_load), .tx_byte(tx_byte),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .cmd_strobe(cmd_strobe), .cmd_code(cmd_code)
    );

    spm_mem #(.ADDR_W(ADDR_W)) mem_i (
        .clk(clk), .we(mem_we), .addr(mem_addr),
        .wdata(mem_wdata), .rdata(rd_data)
    );
endmodule

// File: rtl/spm_port_chk.sv
module spm_port_chk #(
    parameter int ADDR_W = 11
) (
    input logic              clk,
    input logic              rst,
    input logic              cmd_strobe,
    input logic [7:0]        cmd_code,
    input logic              miso,
    input logic              miso_oe,
    input logic              mem_we,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              cs_act
);
    // R6
    strobe_single_chk: assert property (@(posedge clk) disable iff (rst)
        cmd_strobe |=> !cmd_strobe);

    // R6
    strobe_code_chk: assert property (@(posedge clk) disable iff (rst)
        cmd_strobe |-> (cmd_code != 8'hFF && cmd_code[7:3] != 5'b00011
                        && cmd_code[7:3] != 5'b00111));

    // R2
    oe_start_high_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(miso_oe) |-> miso);

    // R10
    oe_select_chk: assert property (@(posedge clk) disable iff (rst)
        miso_oe |-> $past(cs_act));

    // R3
    write_select_chk: assert property (@(posedge clk) disable iff (rst)
        mem_we |-> cs_act);

    // R8
    addr_wrap_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_we && mem_addr == {ADDR_W{1'b1}}) |=> mem_addr == '0);
endmodule

bind spi_pktmem_port spm_port_chk #(.ADDR_W(ADDR_W)) chk_i (
    .clk(clk), .rst(rst), .cmd_strobe(cmd_strobe), .cmd_code(cmd_code),
    .miso(miso), .miso_oe(miso_oe), .mem_we(mem_we),
    .mem_addr(mem_addr), .cs_act(cs_act)
);

// File: tb/spi_pktmem_port_tb_top.sv
`timescale 1ns/1ps
module spi_pktmem_port_tb_top;
    localparam int HALF = 6;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic sclk = 1'b1, csn = 1'b1, mosi = 1'b0;
    logic miso, miso_oe;
    logic irq_pend = 1'b0, ctrl_ready = 1'b0;
    logic [4:0] ctrl_state = 5'd0;
    logic cmd_strobe;
    logic [7:0] cmd_code;

    int n_run = 0, n_fail = 0;
    int strobe_cnt = 0;
    logic [7:0] last_code = 8'h00;
    logic [7:0] model [0:2047];
    bit         valid [0:2047];
    logic [7:0] wbuf [0:15];
    logic [7:0] rbuf [0:15];
    bit done = 1'b0;

    always #5 clk = ~clk;

    spi_pktmem_port dut_i (
        .clk(clk), .rst(rst), .sclk(sclk), .csn(csn), .mosi(mosi),
        .miso(miso), .miso_oe(miso_oe), .irq_pend(irq_pend),
        .ctrl_ready(ctrl_ready), .ctrl_state(ctrl_state),
        .cmd_strobe(cmd_strobe), .cmd_code(cmd_code)
    );

    always @(negedge clk) begin
        if (cmd_strobe) begin
            strobe_cnt = strobe_cnt + 1;
            last_code  = cmd_code;
        end
    end

    function automatic logic [7:0] exp_status(logic i, logic c, logic [4:0] s);
        return {1'b1, i, c, s};
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bits_x(input logic [7:0] tx, input int nb, output logic [7:0] rx);
        rx = 8'h00;
        for (int i = 7; i > 7 - nb; i--) begin
            sclk = 1'b0;
            mosi = tx[i];
            repeat (HALF) @(negedge clk);
            rx[i] = miso;
            sclk = 1'b1;
            repeat (HALF) @(negedge clk);
        end
    endtask

    task automatic byte_x(input logic [7:0] tx, output logic [7:0] rx);
        bits_x(tx, 8, rx);
    endtask

    task automatic cs_begin();
        csn = 1'b0;
        repeat (6) @(negedge clk);
    endtask

    task automatic cs_end();
        repeat (2) @(negedge clk);
        csn = 1'b1;
        repeat (8) @(negedge clk);
    endtask

    task automatic mem_write(input logic [10:0] a, input int n);
        logic [7:0] d;
        cs_begin();
        byte_x(8'h18 | {5'b0, a[10:8]}, d);
        byte_x(a[7:0], d);
        for (int k = 0; k < n; k++) begin
            byte_x(wbuf[k], d);
            model[11'(a + k)] = wbuf[k];
            valid[11'(a + k)] = 1'b1;
        end
        cs_end();
    endtask

    task automatic mem_read(input logic [10:0] a, input int n);
        logic [7:0] d;
        cs_begin();
        byte_x(8'h38 | {5'b0, a[10:8]}, d);
        byte_x(a[7:0], d);
        byte_x(8'hFF, d);
        for (int k = 0; k < n; k++) begin
            byte_x(8'hFF, d);
            rbuf[k] = d;
        end
        cs_end();
    endtask

    task automatic get_status(output logic [7:0] st);
        logic [7:0] d;
        cs_begin();
        byte_x(8'hFF, d);
        byte_x(8'hFF, st);
        cs_end();
    endtask

    task automatic read_check(input string req, input logic [10:0] a, input int n);
        mem_read(a, n);
        for (int k = 0; k < n; k++)
            if (valid[11'(a + k)])
                check(req, rbuf[k], model[11'(a + k)]);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        logic [7:0] d, st;
        int sc;
        void'($urandom(32'h1F2E3D4C));
        for (int k = 0; k < 2048; k++) valid[k] = 1'b0;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R9 reset state
        check("R9 oe", miso_oe, 0);
        check("R9 miso", miso, 1);
        check("R9 strobe", cmd_strobe, 0);

        // R2 ready high after select; R5 status
        irq_pend = 1'b1; ctrl_ready = 1'b0; ctrl_state = 5'h12;
        cs_begin();
        check("R2 oe", miso_oe, 1);
        check("R2 miso", miso, 1);
        byte_x(8'hFF, d);
        byte_x(8'hFF, st);
        cs_end();
        check("R5 status", st, exp_status(1'b1, 1'b0, 5'h12));
        // R10 oe released
        check("R10 oe", miso_oe, 0);

        // R3/R4/R1 mid-range write and read
        wbuf[0] = 8'hA5; wbuf[1] = 8'h3C; wbuf[2] = 8'h81; wbuf[3] = 8'h7E;
        mem_write(11'h523, 4);
        read_check("R4 R3 R1 readback", 11'h523, 4);

        // R8 wrap
        wbuf[0] = 8'h11; wbuf[1] = 8'h22; wbuf[2] = 8'h33;
        mem_write(11'h7FE, 3);
        read_check("R8 wrap", 11'h7FF, 2);
        read_check("R8 low", 11'h000, 1);

        // R7 partial byte
        wbuf[0] = 8'hAA; wbuf[1] = 8'hBB;
        mem_write(11'h050, 2);
        cs_begin();
        byte_x(8'h18, d);
        byte_x(8'h50, d);
        byte_x(8'h44, d);
        bits_x(8'h99, 4, d);
        cs_end();
        model[11'h050] = 8'h44;
        read_check("R7 partial", 11'h050, 2);

        // R6 forwarded command, following bytes ignored
        sc = strobe_cnt;
        cs_begin();
        byte_x(8'hB1, d);
        byte_x(8'h18, d);
        byte_x(8'h00, d);
        byte_x(8'h5A, d);
        cs_end();
        check("R6 count", strobe_cnt, sc + 1);
        check("R6 code", last_code, 8'hB1);
        read_check("R6 no data phase", 11'h000, 1);

        // random mix
        for (int it = 0; it < 40; it++) begin
            int kind;
            kind = $urandom_range(0, 3);
            if (kind == 0) begin
                logic [10:0] a;
                int n;
                a = 11'($urandom);
                n = $urandom_range(1, 8);
                for (int k = 0; k < n; k++) wbuf[k] = 8'($urandom);
                mem_write(a, n);
                read_check("R3 R4 random", a, n);
            end else if (kind == 1) begin
                logic [4:0] s;
                logic i, c;
                s = 5'($urandom); i = 1'($urandom); c = 1'($urandom);
                irq_pend = i; ctrl_ready = c; ctrl_state = s;
                get_status(st);
                check("R5 random status", st, exp_status(i, c, s));
            end else if (kind == 2) begin
                logic [7:0] cd;
                cd = 8'h80 | 8'($urandom_range(0, 126));
                sc = strobe_cnt;
                cs_begin();
                byte_x(cd, d);
                byte_x(8'($urandom), d);
                cs_end();
                check("R6 random count", strobe_cnt, sc + 1);
                check("R6 random code", last_code, cd);
            end else begin
                read_check("R4 random reread", 11'h523, 4);
            end
        end

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule